// File: doc/BRIEF.md
# Two-Phase Shift-and-Signature Scan Filter

This block screens a byte stream before any exact pattern search is attempted. It collects the incoming bytes into a fixed-width window. For each full window it issues one combined lookup to an external match bank made of several banks. Each bank answers two questions about the window at the same time: whether it falls in the skip region, which gives a short shift count, and whether its prefix carries a known signature, which gives an entry number. A skip hit with a nonzero count moves the window forward by that many bytes without any further work.

Otherwise the signature answer decides the outcome. A signature hit produces a candidate record, and the window then moves on by one byte. A signature miss moves the window by one byte and produces nothing.

Only the windows that pass both stages leave the block. Each one leaves as a record holding its stream offset and the matched entry, and a later stage uses these records for exact matching. The filter makes one decision per clock. It accepts one input byte per clock, except while the candidate output is backpressured and holds a decision.

Top module: `scan_filter`

## Requirements
- R1: While reset is asserted and in the cycle after it, `cand_valid` and `lk_valid` are 0 and `in_ready` is 1.
- R2: `lk_valid` is 1 exactly when 4 accepted bytes are waiting in the window. `lk_key` carries the oldest byte (the window start) in bits [7:0], and each later byte sits 8 bits higher.
- R3: Bank b reports its skip answer on `no_hit[b]` with a count on `no_shift[2b+1:2b]`, and its signature answer on `yes_hit[b]` with an entry on `yes_idx[9b+8:9b]`. When several banks hit, the lowest-numbered bank supplies the count, and likewise the entry. `cand_idx` is {bank number in bits [10:9], entry in bits [8:0]}.
- R4: A skip hit with a nonzero count s advances the window start by s bytes in that cycle. The signature answer is then ignored and no candidate is produced.
- R5: When there is no skip hit, or the selected count is zero, a signature hit produces one candidate. The window advances by exactly one byte whether or not the signature hits.
- R6: `cand_off` is the number of bytes accepted before the candidate window's first byte, counting the first byte after reset as offset 0.
- R7: `in_ready` is 1 whenever the window is not full, and also whenever the window is full and its decision completes in that cycle. The block therefore takes one byte per clock when it is not stalled.
- R8: `cand_valid` stays high with a stable offset and entry until `cand_ready` is seen. If a decision needs the output while the output is occupied and not being drained, the window, the offset and the key are held and `in_ready` is 0. No window is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Input byte taken this cycle when valid |
| in_byte | input | 8 | Input stream byte |
| lk_valid | output | 1 | Lookup key is a full window |
| lk_key | output | 32 | Window bytes, oldest in the low byte |
| no_hit | input | 4 | Per-bank skip-table hit |
| no_shift | input | 8 | Per-bank shift count, 2 bits per bank |
| yes_hit | input | 4 | Per-bank signature hit |
| yes_idx | input | 36 | Per-bank signature entry, 9 bits per bank |
| cand_valid | output | 1 | Candidate record present |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_off | output | 32 | Stream offset of the candidate window |
| cand_idx | output | 11 | Bank and entry of the matching signature |

## Verification
Two functions can fall in the same cycle. One is the draining of a held candidate. The other is the production of a new candidate by the next window, which must reload the output register in that same clock without a stall. The bench raises the likelihood of this pairing by making signature hits frequent and driving `cand_ready` at random, so drains, reloads and stalls mix freely. A reference model decides from the port values of each cycle whether that cycle must stall. It then checks `in_ready`, the presented key and the candidate sequence against its own record of the stream.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int SCAN_BYTE_W    = 8;
    localparam int SCAN_WIN_BYTES = 4;
    localparam int SCAN_BANKS     = 4;
    localparam int SCAN_SHIFT_W   = 2;
    localparam int SCAN_ENTRY_W   = 9;
    localparam int SCAN_OFF_W     = 32;

    typedef enum logic [1:0] {
        ACT_WAIT = 2'd0,
        ACT_SKIP = 2'd1,
        ACT_PASS = 2'd2,
        ACT_EMIT = 2'd3
    } scan_act_e;

    function automatic scan_act_e pick_act(logic full, logic skip_hit, logic sig_hit);
        if (!full)
            return ACT_WAIT;
        else if (skip_hit)
            return ACT_SKIP;
        else if (sig_hit)
            return ACT_EMIT;
        else
            return ACT_PASS;
    endfunction

endpackage

// File: rtl/scan_window.sv
module scan_window #(
    parameter int WIN_BYTES = 4,
    parameter int OFF_W     = 32,
    localparam int BW       = 8,
    localparam int CNT_W    = $clog2(WIN_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  logic [BW-1:0]           push_byte,
    input  logic                    adv,
    input  logic [CNT_W-1:0]        adv_cnt,
    output logic [WIN_BYTES*BW-1:0] key,
    output logic                    full,
    output logic [OFF_W-1:0]        offset
);
    logic [BW-1:0]    win_q [WIN_BYTES];
    logic [BW-1:0]    win_d [WIN_BYTES];
    logic [CNT_W-1:0] cnt_q, cnt_d, base;
    logic [OFF_W-1:0] off_q;

    always_comb begin
        base  = adv ? adv_cnt : '0;
        cnt_d = cnt_q - base;
        for (int i = 0; i < WIN_BYTES; i++) begin
            int j;
            j = i + int'(base);
            win_d[i] = (j < WIN_BYTES) ? win_q[j] : '0;
        end
        if (push) begin
            win_d[cnt_d] = push_byte;
            cnt_d        = cnt_d + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            off_q <= '0;
            for (int i = 0; i < WIN_BYTES; i++) win_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            off_q <= off_q + OFF_W'(base);
            for (int i = 0; i < WIN_BYTES; i++) win_q[i] <= win_d[i];
        end
    end

    generate
        for (genvar g = 0; g < WIN_BYTES; g++) begin : g_key
            assign key[g*BW +: BW] = win_q[g];
        end
    endgenerate

    assign full   = (cnt_q == CNT_W'(WIN_BYTES));
    assign offset = off_q;
endmodule

// File: rtl/scan_merge.sv
module scan_merge #(
    parameter int BANKS   = 4,
    parameter int SHIFT_W = 2,
    parameter int ENTRY_W = 9,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [BANKS-1:0]         no_hit,
    input  logic [BANKS*SHIFT_W-1:0] no_shift,
    input  logic [BANKS-1:0]         yes_hit,
    input  logic [BANKS*ENTRY_W-1:0] yes_idx,
    output logic                     no_any,
    output logic [SHIFT_W-1:0]       sel_shift,
    output logic                     yes_any,
    output logic [BANK_W+ENTRY_W-1:0] sel_idx
);
    logic [SHIFT_W-1:0] shift_b [BANKS];
    logic [ENTRY_W-1:0] entry_b [BANKS];

    generate
        for (genvar g = 0; g < BANKS; g++) begin : g_split
            assign shift_b[g] = no_shift[g*SHIFT_W +: SHIFT_W];
            assign entry_b[g] = yes_idx[g*ENTRY_W +: ENTRY_W];
        end
    endgenerate

    // Walk from the highest bank down so the lowest hitting bank wins.
    always_comb begin
        no_any    = 1'b0;
        sel_shift = '0;
        yes_any   = 1'b0;
        sel_idx   = '0;
        for (int b = BANKS - 1; b >= 0; b--) begin
            if (no_hit[b]) begin
                no_any    = 1'b1;
                sel_shift = shift_b[b];
            end
            if (yes_hit[b]) begin
                yes_any = 1'b1;
                sel_idx = {BANK_W'(b), entry_b[b]};
            end
        end
    end
endmodule

// File: rtl/scan_cand_reg.sv
module scan_cand_reg #(
    parameter int DATA_W = 43
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              can_load,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/scan_filter.sv
module scan_filter
    import scan_pkg::*;
#(
    parameter int WIN_BYTES = SCAN_WIN_BYTES,
    parameter int BANKS     = SCAN_BANKS,
    parameter int SHIFT_W   = SCAN_SHIFT_W,
    parameter int ENTRY_W   = SCAN_ENTRY_W,
    parameter int OFF_W     = SCAN_OFF_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [SCAN_BYTE_W-1:0]               in_byte,
    output logic                                 lk_valid,
    output logic [WIN_BYTES*SCAN_BYTE_W-1:0]     lk_key,
    input  logic [BANKS-1:0]                     no_hit,
    input  logic [BANKS*SHIFT_W-1:0]             no_shift,
    input  logic [BANKS-1:0]                     yes_hit,
    input  logic [BANKS*ENTRY_W-1:0]             yes_idx,
    output logic                                 cand_valid,
    input  logic                                 cand_ready,
    output logic [OFF_W-1:0]                     cand_off,
    output logic [$clog2(BANKS)+ENTRY_W-1:0]     cand_idx
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int IDX_W  = BANK_W + ENTRY_W;
    localparam int CNT_W  = $clog2(WIN_BYTES + 1);

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [IDX_W-1:0] idx;
    } cand_t;

    logic               win_full, push, adv, stall, cand_load, can_load;
    logic [CNT_W-1:0]   adv_cnt;
    logic [OFF_W-1:0]   win_off;
    logic               no_any, yes_any, skip_hit;
    logic [SHIFT_W-1:0] sel_shift;
    logic [IDX_W-1:0]   sel_idx;
    scan_act_e          act;
    cand_t              cand_in, cand_out;

    scan_merge #(.BANKS(BANKS), .SHIFT_W(SHIFT_W), .ENTRY_W(ENTRY_W)) u_merge (
        .no_hit(no_hit), .no_shift(no_shift), .yes_hit(yes_hit), .yes_idx(yes_idx),
        .no_any(no_any), .sel_shift(sel_shift), .yes_any(yes_any), .sel_idx(sel_idx)
    );

    // A zero count means "look at the signature now", not "stay put".
    assign skip_hit  = no_any && (sel_shift != '0);
    assign act       = pick_act(win_full, skip_hit, yes_any);
    assign stall     = (act == ACT_EMIT) && !can_load;
    assign adv       = win_full && !stall;
    assign adv_cnt   = (act == ACT_SKIP) ? CNT_W'(sel_shift) : CNT_W'(1);
    assign in_ready  = !win_full || adv;
    assign push      = in_valid && in_ready;
    assign cand_load = (act == ACT_EMIT) && can_load;
    assign cand_in   = '{off: win_off, idx: sel_idx};

    scan_window #(.WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W)) u_window (
        .clk(clk), .rst(rst), .push(push), .push_byte(in_byte),
        .adv(adv), .adv_cnt(adv_cnt), .key(lk_key), .full(win_full), .offset(win_off)
    );

    scan_cand_reg #(.DATA_W($bits(cand_t))) u_cand (
        .clk(clk), .rst(rst), .load(cand_load), .load_data(cand_in),
        .can_load(can_load), .out_valid(cand_valid), .out_ready(cand_ready),
        .out_data(cand_out)
    );

    assign lk_valid = win_full;
    assign cand_off = cand_out.off;
    assign cand_idx = cand_out.idx;
endmodule

// File: rtl/scan_filter_chk.sv
module scan_filter_chk #(
    parameter int KEY_W   = 32,
    parameter int SHIFT_W = 2,
    parameter int OFF_W   = 32,
    parameter int IDX_W   = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               in_ready,
    input logic               lk_valid,
    input logic [KEY_W-1:0]   lk_key,
    input logic               hit0,
    input logic [SHIFT_W-1:0] shift0,
    input logic               cand_valid,
    input logic               cand_ready,
    input logic [OFF_W-1:0]   cand_off,
    input logic [IDX_W-1:0]   cand_idx,
    input logic [OFF_W-1:0]   win_off,
    input logic               cand_load
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !cand_valid && !lk_valid && in_ready);

    p_ready_not_full_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> in_ready);

    p_skip_offset_r4: assert property (@(posedge clk) disable iff (rst)
        lk_valid && hit0 && (shift0 != '0)
        |=> win_off == $past(win_off) + OFF_W'($past(shift0)));

    p_skip_no_cand_r4: assert property (@(posedge clk) disable iff (rst)
        lk_valid && hit0 && (shift0 != '0) && !cand_valid |=> !cand_valid);

    p_cand_offset_r6: assert property (@(posedge clk) disable iff (rst)
        cand_load |=> cand_valid && (cand_off == $past(win_off)));

    p_cand_hold_r8: assert property (@(posedge clk) disable iff (rst)
        cand_valid && !cand_ready |=> cand_valid && $stable(cand_off) && $stable(cand_idx));

    p_stall_key_r8: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !in_ready |=> lk_valid && $stable(lk_key) && $stable(win_off));
endmodule

bind scan_filter scan_filter_chk #(
    .KEY_W(WIN_BYTES*8), .SHIFT_W(SHIFT_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .lk_valid(lk_valid), .lk_key(lk_key),
    .hit0(no_hit[0]), .shift0(no_shift[SHIFT_W-1:0]),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_off(cand_off),
    .cand_idx(cand_idx), .win_off(win_off), .cand_load(cand_load)
);

// File: tb/scan_filter_test.sv
`timescale 1ns/1ps
module scan_filter_test;
    localparam int NB = 700;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [7:0]  in_byte;
    logic        lk_valid;
    logic [31:0] lk_key;
    logic [3:0]  no_hit, yes_hit;
    logic [7:0]  no_shift;
    logic [35:0] yes_idx;
    logic        cand_valid, cand_ready;
    logic [31:0] cand_off;
    logic [10:0] cand_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    scan_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .lk_valid(lk_valid), .lk_key(lk_key), .no_hit(no_hit), .no_shift(no_shift),
        .yes_hit(yes_hit), .yes_idx(yes_idx), .cand_valid(cand_valid),
        .cand_ready(cand_ready), .cand_off(cand_off), .cand_idx(cand_idx)
    );

    // Match bank stand-in: bank b hits the skip table when key bit 4+b is set,
    // with count (key[1:0]+b) mod 4; signature hit when key bit 12+b is set.
    always_comb begin
        for (int b = 0; b < 4; b++) begin
            no_hit[b]         = lk_key[4+b];
            no_shift[2*b +: 2] = lk_key[1:0] + 2'(b);
            yes_hit[b]        = lk_key[12+b];
            yes_idx[9*b +: 9] = {lk_key[24], lk_key[23:16]} ^ 9'(b);
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] bytes [NB];
    int q_off[$];
    int q_idx[$];

    initial begin
        int nin, pos, cyc;
        string ktag;
        for (int i = 0; i < NB; i++) bytes[i] = (i < 16) ? 8'h00 : 8'($urandom);
        // Hand-made patch: several skip banks with a zero count, several signature banks.
        bytes[40] = 8'hE3; bytes[41] = 8'h70; bytes[42] = 8'h5A; bytes[43] = 8'h01;
        rst = 1'b1; in_valid = 1'b0; in_byte = '0; cand_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cand_valid && !lk_valid && in_ready, "R1 reset outputs",
              {cand_valid, lk_valid, in_ready}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        check(!cand_valid && !lk_valid && in_ready, "R1 after reset",
              {cand_valid, lk_valid, in_ready}, 3'b001);
        nin = 0; pos = 0; cyc = 0; ktag = "R2";
        forever begin
            bit full_m, skip_m, emit_m, stall_m, exp_rdy;
            int s_m, idx_m;
            logic [31:0] ek;
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "watchdog", cyc, 20000);
                break;
            end
            if (nin >= NB && (nin - pos) < 4 && q_off.size() == 0) break;
            in_valid   = (nin < NB) && ((nin < 200) || ($urandom_range(99) < 70));
            in_byte    = (nin < NB) ? bytes[nin] : 8'h00;
            cand_ready = (nin < 200) ? 1'b1 : ($urandom_range(99) < 45);
            #1;
            full_m = (nin - pos) >= 4;
            check(lk_valid == full_m, "R2 lk_valid", lk_valid, full_m);
            skip_m = 0; emit_m = 0; s_m = 1; idx_m = 0; ek = '0;
            if (full_m) begin
                ek = {bytes[pos+3], bytes[pos+2], bytes[pos+1], bytes[pos]};
                check(lk_key == ek, ktag, lk_key, ek);
                for (int b = 0; b < 4; b++)
                    if (ek[4+b]) begin
                        s_m = (ek[1:0] + b) % 4;
                        break;
                    end
                if (ek[7:4] == 0) s_m = 0;
                skip_m = (s_m != 0);
                if (!skip_m) begin
                    s_m = 1;
                    for (int b = 0; b < 4; b++)
                        if (ek[12+b]) begin
                            emit_m = 1;
                            idx_m  = (b << 9) | ({ek[24], ek[23:16]} ^ b);
                            break;
                        end
                end
            end
            stall_m = full_m && emit_m && (q_off.size() > 0) && !cand_ready;
            exp_rdy = !full_m || !stall_m;
            check(in_ready == exp_rdy, stall_m ? "R8 stall in_ready" : "R7 in_ready",
                  in_ready, exp_rdy);
            check(cand_valid == (q_off.size() > 0), "R8 cand_valid", cand_valid, q_off.size() > 0);
            if (cand_valid && cand_ready && q_off.size() > 0) begin
                int eo, ei;
                eo = q_off.pop_front();
                ei = q_idx.pop_front();
                check(cand_off == 32'(eo), "R6 cand_off", cand_off, eo);
                check(cand_idx == 11'(ei), "R3 R5 cand_idx", cand_idx, ei);
            end
            if (full_m && !stall_m) begin
                if (emit_m) begin
                    q_off.push_back(pos);
                    q_idx.push_back(idx_m);
                end
                pos  += s_m;
                ktag = skip_m ? "R4 key after skip" : "R5 key after one-byte step";
            end else if (full_m) begin
                ktag = "R8 key held";
            end
            if (in_valid && in_ready) nin++;
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule